// File: doc/BRIEF.md
# Masked Dual-Rail AND Gate with Completion Gating

This block is a synthesizable behavioural model of a vector of masked dual-rail precharge gates that cannot evaluate early. Each lane takes two masked operands and a mask, each on a pair of rails. A data value `d` travels as `d XOR mask` on the true rail and as its complement on the false rail. All rails idle at 0 while the lane is in precharge. During evaluation, exactly one rail of each valid pair rises.

Each lane has a completion detector: one OR per pair feeding a NAND. The detector releases three set-reset gate latches only when all three pairs carry a differential code. Two majority functions of the latched rails then form the masked result. A lane therefore produces no output edge before its last operand has arrived, whatever the arrival order. It also returns to precharge only when the detector clears the latches, never because one input rail falls.

A build-time parameter exchanges the two mask rails. This turns every lane into the OR form of the gate.

In this model the latches are registers clocked by `clk`. The output follows the inputs by one clock in both directions.

Top module: `masked_dualrail_gate`

## Requirements
- R1: While `rst` is high, and on the clock after it, every bit of `qm` and `qm_n` is 0.
- R2: For each lane, if any of its three pairs is 00 (precharged) at a clock edge, that lane's `qm` and `qm_n` are both 0 after the edge.
- R3: On the first clock edge at which all three pairs of a lane are differential, that lane captures its inputs. From then on, exactly one of `qm`/`qm_n` is 1, and `qm` equals `(a AND b) XOR mask`, where `a = am XOR m` and `b = bm XOR m`.
- R4: The arrival order of the three pairs has no effect. In every one of the six orders, the outputs of the lane stay 0 until the edge after the last pair becomes differential.
- R5: While a lane stays complete over consecutive edges, a pair that moves directly from one differential code to the other does not change the lane's outputs.
- R6: If a single pair of a lane falls back to 00 while the other two stay valid, both outputs go to 0 after the next edge. When that pair becomes valid again, the outputs show the new operands.
- R7: With `OR_FORM = 1`, the mask rails are exchanged and `qm` equals `(a OR b) XOR mask`, with the same timing as R3.
- R8: Lanes are independent. A lane's outputs depend only on its own six input rails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the gate latches |
| rst | input | 1 | Synchronous active-high reset that clears all latches |
| am | input | LANES | True rail of masked operand a |
| am_n | input | LANES | False rail of masked operand a |
| bm | input | LANES | True rail of masked operand b |
| bm_n | input | LANES | False rail of masked operand b |
| m | input | LANES | True rail of the mask |
| m_n | input | LANES | False rail of the mask |
| qm | output | LANES | True rail of the masked result |
| qm_n | output | LANES | False rail of the masked result |

## Verification
The AND and OR forms run side by side on the same stimulus.

- **Arrival orders.** The three pairs are brought up one per clock in all six orders. This shows whether the output edge waits for the last arrival or fires on an earlier one.
- **Single-pair drop.** A drop-and-restore of one pair separates detector-driven precharge from precharge that follows an input.
- **Direct code flips.** Flipping a pair from one differential code to the other during evaluation shows that the latches hold their values.
- **Random lane patterns.** Random operands, masks and per-lane validity cover every truth-table row under both mask values. They also catch lanes disturbing one another.

// File: rtl/mdr_pkg.sv
package mdr_pkg;

    typedef struct packed {
        logic t;
        logic f;
    } rail_t;

    typedef struct packed {
        rail_t opa;
        rail_t opb;
        rail_t msk;
    } lane_rails_t;

    localparam int unsigned PAIRS = 3;

    function automatic logic rail_live(input rail_t r);
        return r.t | r.f;
    endfunction

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/mdr_completion.sv
module mdr_completion
    import mdr_pkg::*;
(
    input  lane_rails_t rails,
    output logic        hold_pre
);
    logic [PAIRS-1:0] live;

    always_comb begin
        live[0] = rail_live(rails.opa);
        live[1] = rail_live(rails.opb);
        live[2] = rail_live(rails.msk);
        hold_pre = ~(&live);
    end
endmodule

// File: rtl/mdr_gate_latch.sv
module mdr_gate_latch
    import mdr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hold_pre,
    input  lane_rails_t rails_in,
    output lane_rails_t rails_held
);
    logic armed;

    // The latch bank is empty exactly when nothing has been captured yet.
    always_comb armed = rail_live(rails_held.msk);

    always_ff @(posedge clk) begin
        if (rst || hold_pre) begin
            rails_held <= '0;
        end else if (!armed) begin
            rails_held <= rails_in;
        end
    end
endmodule

// File: rtl/mdr_majority.sv
module mdr_majority
    import mdr_pkg::*;
#(
    parameter bit OR_FORM = 1'b0
) (
    input  lane_rails_t held,
    output logic        q_t,
    output logic        q_f
);
    logic k_t;
    logic k_f;

    generate
        if (OR_FORM) begin : g_swap
            always_comb begin
                k_t = held.msk.f;
                k_f = held.msk.t;
            end
        end else begin : g_keep
            always_comb begin
                k_t = held.msk.t;
                k_f = held.msk.f;
            end
        end
    endgenerate

    always_comb begin
        q_t = maj3(held.opa.t, held.opb.t, k_t);
        q_f = maj3(held.opa.f, held.opb.f, k_f);
    end
endmodule

// File: rtl/masked_dualrail_gate.sv
module masked_dualrail_gate
    import mdr_pkg::*;
#(
    parameter int unsigned LANES   = 4,
    parameter bit          OR_FORM = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] am,
    input  logic [LANES-1:0] am_n,
    input  logic [LANES-1:0] bm,
    input  logic [LANES-1:0] bm_n,
    input  logic [LANES-1:0] m,
    input  logic [LANES-1:0] m_n,
    output logic [LANES-1:0] qm,
    output logic [LANES-1:0] qm_n
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_rails_t in_r;
        lane_rails_t held_r;
        logic        pre;

        always_comb begin
            in_r.opa = '{t: am[i], f: am_n[i]};
            in_r.opb = '{t: bm[i], f: bm_n[i]};
            in_r.msk = '{t: m[i],  f: m_n[i]};
        end

        mdr_completion u_det (
            .rails    (in_r),
            .hold_pre (pre)
        );

        mdr_gate_latch u_lat (
            .clk        (clk),
            .rst        (rst),
            .hold_pre   (pre),
            .rails_in   (in_r),
            .rails_held (held_r)
        );

        mdr_majority #(.OR_FORM(OR_FORM)) u_maj (
            .held (held_r),
            .q_t  (qm[i]),
            .q_f  (qm_n[i])
        );
    end
endmodule

// File: rtl/mdr_gate_checker.sv
module mdr_gate_checker #(
    parameter int unsigned LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] am,
    input logic [LANES-1:0] am_n,
    input logic [LANES-1:0] bm,
    input logic [LANES-1:0] bm_n,
    input logic [LANES-1:0] m,
    input logic [LANES-1:0] m_n,
    input logic [LANES-1:0] qm,
    input logic [LANES-1:0] qm_n
);
    logic [LANES-1:0] full;
    logic [LANES-1:0] partial;
    logic [LANES-1:0] full_q;
    logic [LANES-1:0] steady;

    always_comb begin
        full    = (am | am_n) & (bm | bm_n) & (m | m_n);
        partial = ~full;
        steady  = full & full_q;
    end

    always_ff @(posedge clk) begin
        if (rst) full_q <= '0;
        else     full_q <= full;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (qm == '0 && qm_n == '0));

    // R2 and R4: no output rail of a lane rises while one of its pairs is still precharged
    a_r2_no_early_eval: assert property (@(posedge clk) disable iff (rst)
        (|partial) |=> (((qm | qm_n) & $past(partial)) == '0));

    a_r3_one_hot_result: assert property (@(posedge clk) disable iff (rst)
        (|full) |=> (((qm ^ qm_n) & $past(full)) == $past(full)));

    a_r5_hold_while_complete: assert property (@(posedge clk) disable iff (rst)
        (|steady) |=> ((((qm ^ $past(qm)) | (qm_n ^ $past(qm_n))) & $past(steady)) == '0));
endmodule

bind masked_dualrail_gate mdr_gate_checker #(.LANES(LANES)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .am   (am),
    .am_n (am_n),
    .bm   (bm),
    .bm_n (bm_n),
    .m    (m),
    .m_n  (m_n),
    .qm   (qm),
    .qm_n (qm_n)
);

// File: tb/sim_masked_dualrail_gate.sv
module sim_masked_dualrail_gate;
    localparam int          CLK_PERIOD = 10;
    localparam int unsigned W          = 4;

    typedef struct {
        logic [W-1:0] e0q;
        logic [W-1:0] e0n;
        logic [W-1:0] e1q;
        logic [W-1:0] e1n;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] am = '0, am_n = '0, bm = '0, bm_n = '0, m = '0, m_n = '0;
    logic [W-1:0] q0, q0n, q1, q1n;

    item_t        sb[$];
    int           checks = 0;
    int           errors = 0;
    logic [W-1:0] prev_full = '0;
    logic [W-1:0] p0q = '0, p0n = '0, p1q = '0, p1n = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    masked_dualrail_gate #(.LANES(W), .OR_FORM(1'b0)) u0 (
        .clk(clk), .rst(rst), .am(am), .am_n(am_n), .bm(bm), .bm_n(bm_n),
        .m(m), .m_n(m_n), .qm(q0), .qm_n(q0n));

    masked_dualrail_gate #(.LANES(W), .OR_FORM(1'b1)) u1 (
        .clk(clk), .rst(rst), .am(am), .am_n(am_n), .bm(bm), .bm_n(bm_n),
        .m(m), .m_n(m_n), .qm(q1), .qm_n(q1n));

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Driver: a, b, mk are unmasked values; va/vb/vm say whether each pair is valid.
    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] mk,
                        input logic [W-1:0] va, input logic [W-1:0] vb, input logic [W-1:0] vm,
                        input string tag);
        item_t it;
        logic [W-1:0] full;
        @(negedge clk);
        am   = va & (a ^ mk);
        am_n = va & ~(a ^ mk);
        bm   = vb & (b ^ mk);
        bm_n = vb & ~(b ^ mk);
        m    = vm & mk;
        m_n  = vm & ~mk;
        full = va & vb & vm;
        for (int i = 0; i < W; i++) begin
            if (!full[i]) begin
                p0q[i] = 1'b0; p0n[i] = 1'b0; p1q[i] = 1'b0; p1n[i] = 1'b0;
            end else if (!prev_full[i]) begin
                p0q[i] = (a[i] & b[i]) ^ mk[i]; p0n[i] = ~p0q[i];
                p1q[i] = (a[i] | b[i]) ^ mk[i]; p1n[i] = ~p1q[i];
            end
        end
        prev_full = full;
        it.e0q = p0q; it.e0n = p0n; it.e1q = p1q; it.e1n = p1n; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compares one scoreboard item per clock, after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(q0 == it.e0q,  it.tag, "and qm",   q0,  it.e0q);
                check(q0n == it.e0n, it.tag, "and qm_n", q0n, it.e0n);
                check(q1 == it.e1q,  it.tag, "or qm",    q1,  it.e1q);
                check(q1n == it.e1n, it.tag, "or qm_n",  q1n, it.e1n);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [W-1:0] ALL  = '1;
    localparam logic [W-1:0] NONE = '0;

    initial begin
        logic [W-1:0] ra, rb, rm, v1, v2, v3;

        repeat (3) @(posedge clk);
        #1;
        check(q0 == '0 && q0n == '0 && q1 == '0 && q1n == '0, "R1", "reset outputs",
              q0 | q0n | q1 | q1n, '0);
        @(negedge clk);
        rst = 1'b0;

        // R3 and R7: exhaustive truth table over a, b, mask (lanes carry different rows)
        for (int k = 0; k < 2; k++) begin
            ra = 4'b1010; rb = 4'b1100; rm = k[0] ? 4'b1111 : 4'b0000;
            step(ra, rb, rm, ALL, ALL, ALL, "R3/R7 truth table");
            step(ra, rb, rm, NONE, NONE, NONE, "R2 precharge");
        end

        // R4: all six arrival orders of the three pairs
        for (int p = 0; p < 6; p++) begin
            logic [2:0] s1, s2, s3;
            case (p)
                0: begin s1 = 3'b001; s2 = 3'b010; s3 = 3'b100; end
                1: begin s1 = 3'b001; s2 = 3'b100; s3 = 3'b010; end
                2: begin s1 = 3'b010; s2 = 3'b001; s3 = 3'b100; end
                3: begin s1 = 3'b010; s2 = 3'b100; s3 = 3'b001; end
                4: begin s1 = 3'b100; s2 = 3'b001; s3 = 3'b010; end
                default: begin s1 = 3'b100; s2 = 3'b010; s3 = 3'b001; end
            endcase
            ra = 4'b0110; rb = 4'b0101; rm = 4'(p * 5);
            v1 = {W{s1[0]}}; v2 = {W{s1[1]}}; v3 = {W{s1[2]}};
            step(ra, rb, rm, v1, v2, v3, "R4 first arrival");
            v1 |= {W{s2[0]}}; v2 |= {W{s2[1]}}; v3 |= {W{s2[2]}};
            step(ra, rb, rm, v1, v2, v3, "R4 second arrival");
            step(ra, rb, rm, ALL, ALL, ALL, "R4 last arrival");
            step(ra, rb, rm, NONE, NONE, NONE, "R4 precharge");
        end

        // R5: direct flips while complete are ignored
        step(4'b0011, 4'b0101, 4'b1001, ALL, ALL, ALL, "R5 capture");
        step(4'b1100, 4'b0101, 4'b1001, ALL, ALL, ALL, "R5 flip a held");
        step(4'b1100, 4'b1010, 4'b0110, ALL, ALL, ALL, "R5 flip b and mask held");

        // R6: one pair drops alone, then returns with a new value
        step(4'b1111, 4'b1111, 4'b0000, ALL, ALL, ALL, "R6 evaluate");
        step(4'b1111, 4'b1111, 4'b0000, ALL, NONE, ALL, "R6 single drop clears");
        step(4'b1111, 4'b0000, 4'b0000, ALL, ALL, ALL, "R6 re-evaluate");
        step(4'b1111, 4'b0000, 4'b0000, NONE, NONE, NONE, "R6 precharge");

        // R8: lanes complete at different times
        step(4'b1111, 4'b1111, 4'b0101, 4'b0001, 4'b0011, 4'b0111, "R8 staggered lanes");
        step(4'b1111, 4'b1111, 4'b0101, 4'b0011, 4'b0111, 4'b1111, "R8 staggered lanes");
        step(4'b1111, 4'b1111, 4'b0101, ALL, ALL, ALL, "R8 staggered lanes");
        step(4'b1111, 4'b1111, 4'b0101, NONE, NONE, NONE, "R8 precharge");

        // Random patterns across R2, R3, R5, R7, R8
        for (int n = 0; n < 150; n++) begin
            ra = W'($urandom); rb = W'($urandom); rm = W'($urandom);
            v1 = W'($urandom) | W'($urandom);
            v2 = W'($urandom) | W'($urandom);
            v3 = W'($urandom) | W'($urandom);
            step(ra, rb, rm, v1, v2, v3, "R8 random partial");
            step(ra, rb, rm, ALL, ALL, ALL, "R3 random complete");
            step(~ra, rb, rm, ALL, ALL, ALL, "R5 random hold");
            step(ra, rb, rm, NONE, NONE, NONE, "R2 random precharge");
        end

        @(posedge clk);
        #2;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule